// File: doc/BRIEF.md
# Capability Access Enable and Execution Mode Resolver

This block decides, for each cycle, whether the hart may explicitly touch capability registers and capability instructions. It keeps three enable bits, one for each level of a privilege chain. The machine-level bit sits in the machine security configuration register. The supervisor-level bit sits in the machine environment configuration register. The user-level bit sits in the supervisor environment configuration register. The block combines these bits with the hart's current context: privilege, debug state, register width and data endianness. The result is a single access-enable signal.

Two results are derived from that enable. The first is the effective execution mode: capability or integer. It is resolved from the mode bit of the program-counter capability. The second is an illegal-instruction indication for capability instructions and for capability-gated CSR accesses that are attempted while access is off. The CSR file writes the three bits through a small select/write port and reads them back through the same port. The decode stage uses the outputs combinationally.

Top module: `cap_access_ctrl`

## Requirements
- R1: After synchronous active-low reset, all three enable bits read back as 0. While not in debug state, access is therefore disabled at every privilege.
- R2: When `cfg_we` is 1, the next clock edge loads `cfg_wdata` into the bit chosen by `cfg_sel`: 0 is the machine security bit, 1 is the machine environment bit, 2 is the supervisor environment bit. `cfg_rdata` shows the selected bit combinationally. Select 3 reads as 0, and a write to select 3 changes none of the bits.
- R3: Each bit is written on its own terms. All eight combinations of the three bits can be stored and read back unchanged, including a lower-level bit set while a higher-level bit is clear.
- R4: At machine privilege (`priv` = 2'b11), the chain enable equals the machine security bit alone.
- R5: At supervisor privilege (`priv` = 2'b01), the chain enable is the AND of the machine security bit and the machine environment bit.
- R6: At user privilege (`priv` = 2'b00), and also at the reserved code 2'b10, the chain enable is the AND of all three bits.
- R7: While `debug_mode` is 1, the chain enable is 1 whatever the bits hold.
- R8: When `cur_xlen` is less than `max_xlen`, access is disabled, even in debug state.
- R9: When `cur_big_endian` differs from `mbe_reset_val`, access is disabled, even in debug state.
- R10: `cap_mode` is 1 only when `pcc_mode_bit` is 0 (the capability-mode code) and access is enabled. `eff_mode_bit` is forced to 1 (the integer-mode code) while access is disabled, and otherwise equals `pcc_mode_bit`.
- R11: `illegal_o` is 1 exactly when `cap_insn` or `cap_csr_acc` is 1 while access is disabled.
- R12: Context inputs reach the outputs within the same cycle. A bit write changes the outputs from the cycle after the write edge, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Enable-bit write strobe |
| cfg_sel | input | 2 | Enable-bit select (0 machine security, 1 machine env, 2 supervisor env) |
| cfg_wdata | input | 1 | Value to write |
| cfg_rdata | output | 1 | Selected enable bit |
| priv | input | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| debug_mode | input | 1 | Hart is in debug state |
| cur_xlen | input | XW | Encoded register width of the current mode |
| max_xlen | input | XW | Encoded machine register width |
| cur_big_endian | input | 1 | Endianness of the current mode |
| mbe_reset_val | input | 1 | Reset value of the machine big-endian control |
| pcc_mode_bit | input | 1 | Mode bit of the program-counter capability |
| cap_insn | input | 1 | A capability instruction is being decoded |
| cap_csr_acc | input | 1 | A capability-gated CSR is being accessed |
| access_en | output | 1 | Capability register access enabled |
| cap_mode | output | 1 | Effective mode is capability mode |
| eff_mode_bit | output | 1 | Mode bit as seen by execution (0 capability, 1 integer) |
| illegal_o | output | 1 | Illegal-instruction indication |

## Verification
The resolver is swept over all eight stored bit combinations at each of the four privilege codes. This separates the three chain lengths from one another and catches a reserved code that lands on the wrong chain. Debug state is then applied with every bit clear, which separates the debug override from the chain itself. Width and endianness mismatches are applied in debug state, and this shows that they override the debug override. The mode and illegal outputs are driven with both mode-bit values and both request kinds, on each side of an enabled/disabled flip. That flip is timed against a write edge, so it can be seen whether the bits are registered.

// File: rtl/cap_gate_pkg.sv
// Shared constants and types for the capability access resolver.
// Assumes three privilege levels in the enable chain: machine, supervisor, user.
package cap_gate_pkg;
    localparam int NUM_EN = 3;
    localparam int SEL_W  = 2;

    // Mode-bit code that means capability mode; the other value means integer mode.
    localparam logic CAP_MODE_CODE = 1'b0;

    typedef enum logic [1:0] {
        PRIV_USER  = 2'b00,
        PRIV_SUPER = 2'b01,
        PRIV_RSVD  = 2'b10,
        PRIV_MACH  = 2'b11
    } priv_e;

    typedef enum logic [SEL_W-1:0] {
        SEL_MSEC = 2'd0,
        SEL_MENV = 2'd1,
        SEL_SENV = 2'd2,
        SEL_NONE = 2'd3
    } en_sel_e;
endpackage

// File: rtl/cap_en_regs.sv
// Holds the per-level enable bits (index 0 = machine, rising index = less privileged).
// Assumes one bit per level, written one at a time; out-of-range selects read 0.
module cap_en_regs
    import cap_gate_pkg::*;
#(
    parameter int LEVELS = NUM_EN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic              wr_bit,
    output logic [LEVELS-1:0] en_bits,
    output logic              rd_bit
);
    genvar g;
    generate
        for (g = 0; g < LEVELS; g++) begin : g_bit
            // Storage for one level's enable bit, cleared by reset.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    en_bits[g] <= 1'b0;
                else if (wr_en && (wr_sel == SEL_W'(g)))
                    en_bits[g] <= wr_bit;
            end
        end
    endgenerate

    // Read-back multiplexer for the selected bit.
    always_comb begin
        rd_bit = 1'b0;
        for (int i = 0; i < LEVELS; i++) begin
            if (wr_sel == SEL_W'(i))
                rd_bit = en_bits[i];
        end
    end
endmodule

// File: rtl/cap_en_resolve.sv
// Resolves capability register access from the enable chain and the hart context.
// Assumes the width codes grow with width and that index 0 of en_bits is machine.
module cap_en_resolve
    import cap_gate_pkg::*;
#(
    parameter int LEVELS = NUM_EN,
    parameter int XW     = 2
) (
    input  logic [LEVELS-1:0] en_bits,
    input  logic [1:0]        priv,
    input  logic              debug_mode,
    input  logic [XW-1:0]     cur_xlen,
    input  logic [XW-1:0]     max_xlen,
    input  logic              cur_big_endian,
    input  logic              mbe_reset_val,
    output logic              access_en
);
    localparam int IDX_M = 0;
    localparam int IDX_S = 1;
    localparam int IDX_U = LEVELS - 1;

    logic [LEVELS-1:0] prefix_and;
    logic              chain_ok;
    logic              width_ok;
    logic              endian_ok;

    assign prefix_and[0] = en_bits[0];
    genvar g;
    generate
        for (g = 1; g < LEVELS; g++) begin : g_chain
            assign prefix_and[g] = prefix_and[g-1] & en_bits[g];
        end
    endgenerate

    // Pick the chain depth for the current privilege; debug overrides the chain.
    always_comb begin
        unique case (priv_e'(priv))
            PRIV_MACH:  chain_ok = prefix_and[IDX_M];
            PRIV_SUPER: chain_ok = prefix_and[IDX_S];
            default:    chain_ok = prefix_and[IDX_U];
        endcase
        if (debug_mode)
            chain_ok = 1'b1;
    end

    // Context checks that apply in every state, debug included.
    always_comb begin
        width_ok  = (cur_xlen >= max_xlen);
        endian_ok = (cur_big_endian == mbe_reset_val);
        access_en = chain_ok & width_ok & endian_ok;
    end
endmodule

// File: rtl/cap_mode_gate.sv
// Derives the execution mode and the illegal indication from access enable.
// Assumes requests are single-cycle decode strobes.
module cap_mode_gate
    import cap_gate_pkg::*;
(
    input  logic access_en,
    input  logic pcc_mode_bit,
    input  logic cap_insn,
    input  logic cap_csr_acc,
    output logic cap_mode,
    output logic eff_mode_bit,
    output logic illegal_o
);
    // Mode bit is seen as integer mode while access is off.
    always_comb begin
        eff_mode_bit = access_en ? pcc_mode_bit : ~CAP_MODE_CODE;
        cap_mode     = (eff_mode_bit == CAP_MODE_CODE);
    end

    // Flag any capability request made while access is off.
    always_comb begin
        illegal_o = (cap_insn | cap_csr_acc) & ~access_en;
    end
endmodule

// File: rtl/cap_access_ctrl.sv
// Top: capability access enable bits, access resolver and mode gate.
// Assumes the CSR file decodes addresses into cfg_sel; all outputs are combinational.
module cap_access_ctrl
    import cap_gate_pkg::*;
#(
    parameter int XW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic          cfg_wdata,
    output logic          cfg_rdata,
    input  logic [1:0]    priv,
    input  logic          debug_mode,
    input  logic [XW-1:0] cur_xlen,
    input  logic [XW-1:0] max_xlen,
    input  logic          cur_big_endian,
    input  logic          mbe_reset_val,
    input  logic          pcc_mode_bit,
    input  logic          cap_insn,
    input  logic          cap_csr_acc,
    output logic          access_en,
    output logic          cap_mode,
    output logic          eff_mode_bit,
    output logic          illegal_o
);
    logic [NUM_EN-1:0] en_bits;

    cap_en_regs #(.LEVELS(NUM_EN)) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_sel  (cfg_sel),
        .wr_bit  (cfg_wdata),
        .en_bits (en_bits),
        .rd_bit  (cfg_rdata)
    );

    cap_en_resolve #(.LEVELS(NUM_EN), .XW(XW)) resolve_i (
        .en_bits        (en_bits),
        .priv           (priv),
        .debug_mode     (debug_mode),
        .cur_xlen       (cur_xlen),
        .max_xlen       (max_xlen),
        .cur_big_endian (cur_big_endian),
        .mbe_reset_val  (mbe_reset_val),
        .access_en      (access_en)
    );

    cap_mode_gate gate_i (
        .access_en    (access_en),
        .pcc_mode_bit (pcc_mode_bit),
        .cap_insn     (cap_insn),
        .cap_csr_acc  (cap_csr_acc),
        .cap_mode     (cap_mode),
        .eff_mode_bit (eff_mode_bit),
        .illegal_o    (illegal_o)
    );
endmodule

// File: rtl/cap_access_ctrl_chk.sv
// Checker for cap_access_ctrl, attached by bind; observes top-level ports only.
module cap_access_ctrl_chk #(
    parameter int XW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_we,
    input logic [1:0]    cfg_sel,
    input logic          cfg_wdata,
    input logic          cfg_rdata,
    input logic [1:0]    priv,
    input logic          debug_mode,
    input logic [XW-1:0] cur_xlen,
    input logic [XW-1:0] max_xlen,
    input logic          cur_big_endian,
    input logic          mbe_reset_val,
    input logic          pcc_mode_bit,
    input logic          cap_insn,
    input logic          cap_csr_acc,
    input logic          access_en,
    input logic          cap_mode,
    input logic          eff_mode_bit,
    input logic          illegal_o
);
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!access_en || debug_mode));

    p_write_back_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cfg_we) && ($past(cfg_sel) != 2'd3) && (cfg_sel == $past(cfg_sel)))
        |-> (cfg_rdata == $past(cfg_wdata)));

    p_sel_none_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_sel == 2'd3) |-> !cfg_rdata);

    p_debug_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (debug_mode && (cur_xlen >= max_xlen) && (cur_big_endian == mbe_reset_val)) |-> access_en);

    p_width_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_xlen < max_xlen) |-> !access_en);

    p_endian_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_big_endian != mbe_reset_val) |-> !access_en);

    p_cap_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cap_mode |-> (!pcc_mode_bit && access_en));

    p_int_forced_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !access_en |-> (eff_mode_bit && !cap_mode));

    p_illegal_raise_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((cap_insn || cap_csr_acc) && !access_en) |-> illegal_o);

    p_illegal_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (!access_en && (cap_insn || cap_csr_acc)));
endmodule

bind cap_access_ctrl cap_access_ctrl_chk #(.XW(XW)) chk_i (.*);

// File: tb/cap_access_ctrl_tb_top.sv
`timescale 1ns/1ps
module cap_access_ctrl_tb_top;
    localparam int XW = 2;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cfg_we;
    logic [1:0]    cfg_sel;
    logic          cfg_wdata;
    logic          cfg_rdata;
    logic [1:0]    priv;
    logic          debug_mode;
    logic [XW-1:0] cur_xlen;
    logic [XW-1:0] max_xlen;
    logic          cur_big_endian;
    logic          mbe_reset_val;
    logic          pcc_mode_bit;
    logic          cap_insn;
    logic          cap_csr_acc;
    logic          access_en;
    logic          cap_mode;
    logic          eff_mode_bit;
    logic          illegal_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    cap_access_ctrl #(.XW(XW)) dut_i (.*);

    task automatic chk(input string req, input logic got, input logic exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b", req, got, exp);
        end
    endtask

    // Reference model of access enable, from the requirements.
    function automatic logic ref_en(input logic [2:0] b, input logic [1:0] p,
                                    input logic dbg, input logic [XW-1:0] cx,
                                    input logic [XW-1:0] mx, input logic be,
                                    input logic mbe);
        logic chain;
        case (p)
            2'b11:   chain = b[0];
            2'b01:   chain = b[0] & b[1];
            default: chain = b[0] & b[1] & b[2];
        endcase
        if (dbg) chain = 1'b1;
        return chain & (cx >= mx) & (be == mbe);
    endfunction

    task automatic wr(input logic [1:0] sel, input logic val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_bits(input logic [2:0] b);
        wr(2'd0, b[0]); wr(2'd1, b[1]); wr(2'd2, b[2]);
    endtask

    task automatic settle();
        @(negedge clk); #1;
    endtask

    task automatic t_reset();
        for (int s = 0; s < 3; s++) begin
            cfg_sel = 2'(s); #1;
            chk("R1 bit after reset", cfg_rdata, 1'b0);
        end
        for (int p = 0; p < 4; p++) begin
            priv = 2'(p); #1;
            chk("R1 access after reset", access_en, 1'b0);
        end
    endtask

    task automatic t_rw();
        for (int c = 0; c < 8; c++) begin
            set_bits(3'(c));
            for (int s = 0; s < 3; s++) begin
                cfg_sel = 2'(s); #1;
                chk("R3 readback", cfg_rdata, c[s]);
            end
        end
        set_bits(3'b010);
        wr(2'd3, 1'b1);
        cfg_sel = 2'd3; #1;
        chk("R2 select 3 reads 0", cfg_rdata, 1'b0);
        for (int s = 0; s < 3; s++) begin
            cfg_sel = 2'(s); #1;
            chk("R2 select 3 write ignored", cfg_rdata, (s == 1));
        end
    endtask

    task automatic t_chain();
        for (int c = 0; c < 8; c++) begin
            set_bits(3'(c));
            for (int p = 0; p < 4; p++) begin
                priv = 2'(p); #1;
                chk(p == 3 ? "R4 machine chain" : (p == 1 ? "R5 supervisor chain" : "R6 user/reserved chain"),
                    access_en, ref_en(3'(c), 2'(p), 1'b0, cur_xlen, max_xlen, 1'b0, 1'b0));
            end
        end
    endtask

    task automatic t_debug();
        set_bits(3'b000);
        debug_mode = 1'b1;
        for (int p = 0; p < 4; p++) begin
            priv = 2'(p); #1;
            chk("R7 debug override", access_en, 1'b1);
        end
        debug_mode = 1'b0;
    endtask

    task automatic t_width_endian();
        set_bits(3'b111);
        priv = 2'b11; debug_mode = 1'b1;
        cur_xlen = 2'd1; max_xlen = 2'd2; #1;
        chk("R8 narrow width in debug", access_en, 1'b0);
        cur_xlen = 2'd3; #1;
        chk("R8 wider current width", access_en, 1'b1);
        cur_xlen = 2'd2; cur_big_endian = 1'b1; #1;
        chk("R9 endian mismatch in debug", access_en, 1'b0);
        mbe_reset_val = 1'b1; #1;
        chk("R9 endian match big", access_en, 1'b1);
        debug_mode = 1'b0; cur_big_endian = 1'b0; mbe_reset_val = 1'b0;
    endtask

    task automatic t_mode();
        set_bits(3'b111); priv = 2'b00;
        for (int m = 0; m < 2; m++) begin
            pcc_mode_bit = 1'(m); #1;
            chk("R10 cap_mode enabled", cap_mode, (m == 0));
            chk("R10 eff bit enabled", eff_mode_bit, 1'(m));
        end
        wr(2'd2, 1'b0);
        for (int m = 0; m < 2; m++) begin
            pcc_mode_bit = 1'(m); #1;
            chk("R10 cap_mode disabled", cap_mode, 1'b0);
            chk("R10 eff bit disabled", eff_mode_bit, 1'b1);
        end
    endtask

    task automatic t_illegal();
        set_bits(3'b011);
        for (int p = 0; p < 2; p++) begin
            priv = (p == 0) ? 2'b00 : 2'b01;
            for (int r = 0; r < 4; r++) begin
                cap_insn = r[0]; cap_csr_acc = r[1]; #1;
                chk("R11 illegal", illegal_o, (r != 0) && (p == 0));
            end
        end
        cap_insn = 1'b0; cap_csr_acc = 1'b0;
    endtask

    task automatic t_timing();
        set_bits(3'b000); priv = 2'b11;
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = 1'b1; #1;
        chk("R12 no effect before edge", access_en, 1'b0);
        @(negedge clk);
        cfg_we = 1'b0; #1;
        chk("R12 effect after edge", access_en, 1'b1);
        debug_mode = 1'b0; priv = 2'b01; #1;
        chk("R12 same-cycle context", access_en, 1'b0);
    endtask

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = 2'd0; cfg_wdata = 1'b0;
        priv = 2'b11; debug_mode = 1'b0; cur_xlen = 2'd2; max_xlen = 2'd2;
        cur_big_endian = 1'b0; mbe_reset_val = 1'b0; pcc_mode_bit = 1'b0;
        cap_insn = 1'b0; cap_csr_acc = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();
        t_reset();
        t_rw();
        t_chain();
        t_debug();
        t_width_endian();
        t_mode();
        t_illegal();
        t_timing();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule